// File: doc/BRIEF.md
# Vector saturating narrow-and-place unit

This block is one stage of a SIMD datapath. Each request carries a source vector and the current contents of the destination vector. The source is read as packed wide elements, each 16, 32 or 64 bits. Every element is clamped to half its own width by one of three saturation rules. The narrowed value is then written into its own wide slot of the result.

The placement has two forms. The "low" form puts the narrowed value in the lower half of the slot and clears the upper half. The "high" form puts the narrowed value in the upper half of the slot and keeps the lower half from the destination vector. Running a low request and then a high request on the same destination interleaves two narrowed vectors.

All slots are handled in parallel. The result is registered, so it appears one cycle after the request. Requests that cannot be encoded are rejected with a flag, and the previous result stays in place.

Top module: `vnarrow_sat`

## Requirements
- R1: `size_code` selects the wide element width. Code 0 means 16-bit elements narrowed to 8 bits, code 1 means 32 to 16, and code 2 means 64 to 32. Every wide slot in the vector is processed in the same cycle.
- R2: Mode `op_code[2:1]=00` is signed clamping. Each element is read as signed and limited to the range -(2^(h-1)) to 2^(h-1)-1, where h is the half width.
- R3: Mode `op_code[2:1]=01` is unsigned clamping. Each element is read as unsigned and limited to at most 2^h-1.
- R4: Mode `op_code[2:1]=10` is signed-in, unsigned-out clamping. Each element is read as signed. Negative values become 0, and values above 2^h-1 become 2^h-1.
- R5: When `op_code[0]=0`, each slot carries the h-bit narrowed value in its low half, and its high half is zero.
- R6: When `op_code[0]=1`, each slot carries the narrowed value in its high half, and its low half equals the low half of the same slot of `dst_vec`.
- R7: A request is illegal if `size_code=3`, if `shift_imm` is nonzero, or if `op_code` is 110 or 111. One cycle after an illegal request, `out_valid=1` and `out_illegal=1`, and `out_vec` keeps its earlier value. A legal request gives `out_illegal=0`.
- R8: `out_valid` is high exactly one cycle after each `in_valid` cycle. A cycle with `in_valid` low gives `out_valid=0` and `out_illegal=0` one cycle later, and `out_vec` holds.
- R9: While `rst_n` is low at a clock edge, `out_valid`, `out_illegal` and `out_vec` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op_code | input | 3 | Clamp mode in bits [2:1], high/low placement in bit [0] |
| size_code | input | 2 | Wide element width code |
| shift_imm | input | SHAMT_W | Immediate field; must be zero |
| src_vec | input | VEC_W | Source vector of wide elements |
| dst_vec | input | VEC_W | Current destination vector, used by the high form |
| out_vec | output | VEC_W | Registered result vector |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_illegal | output | 1 | Rejection flag, paired with out_valid |

## Verification
Two functions can fall in the same cycle: a rejection holding the result, and a legal result that has just been written. The bench provokes this by issuing an illegal request in the cycle directly after a legal one. It then checks that the rejection returns the vector the legal request produced, not a reset value or a half-updated value. Saturation in both directions can also land in one vector, and this is provoked by rotating the boundary values across the slots. For the high form, the result is judged against a random destination, so that a lost low half cannot go unnoticed.

// File: rtl/vnarrow_pkg.sv
// Shared types for the saturating narrow unit.
// Assumes 64-bit lanes; the vector width is a multiple of LANE_W.
package vnarrow_pkg;
    localparam int unsigned LANE_W = 64;

    typedef enum logic [1:0] {
        CLAMP_S   = 2'b00,
        CLAMP_U   = 2'b01,
        CLAMP_SU  = 2'b10,
        CLAMP_BAD = 2'b11
    } clamp_e;

    typedef enum logic [1:0] {
        EW16   = 2'd0,
        EW32   = 2'd1,
        EW64   = 2'd2,
        EW_BAD = 2'd3
    } ewidth_e;

    typedef struct packed {
        logic    ok;
        clamp_e  mode;
        logic    top;
        ewidth_e ew;
    } nar_ctl_t;
endpackage

// File: rtl/vnarrow_dec.sv
// Request decoder: splits the op code into clamp mode and placement,
// and flags requests that cannot be encoded.
// Assumes nothing about in_valid; the output is purely combinational.
module vnarrow_dec
    import vnarrow_pkg::*;
#(
    parameter int unsigned SHAMT_W = 3
) (
    input  logic [2:0]         op_code,
    input  logic [1:0]         size_code,
    input  logic [SHAMT_W-1:0] shift_imm,
    output nar_ctl_t           ctl
);
    // Decode fields and legality.
    always_comb begin
        ctl.mode = clamp_e'(op_code[2:1]);
        ctl.top  = op_code[0];
        ctl.ew   = ewidth_e'(size_code);
        ctl.ok   = (size_code != 2'd3) && (shift_imm == '0) && (op_code[2:1] != 2'b11);
    end
endmodule

// File: rtl/vnarrow_elem.sv
// One wide element: clamps E bits to E/2 bits under the selected mode,
// then places the value in the low half (high half zeroed) or in the
// high half (low half taken from the destination).
// Assumes E is even and at least 4.
module vnarrow_elem
    import vnarrow_pkg::*;
#(
    parameter int unsigned E = 16
) (
    input  logic [E-1:0]   src,
    input  logic [E/2-1:0] dst_lo,
    input  clamp_e         mode,
    input  logic           top,
    output logic [E-1:0]   slot
);
    localparam int unsigned H = E / 2;

    logic         neg;
    logic         s_fit;
    logic         u_fit;
    logic [H-1:0] sat;

    // Range tests on the discarded upper bits.
    always_comb begin
        neg   = src[E-1];
        s_fit = (&src[E-1:H-1]) | ~(|src[E-1:H-1]);
        u_fit = ~(|src[E-1:H]);
    end

    // Clamp by mode.
    always_comb begin
        unique case (mode)
            CLAMP_S:  sat = s_fit ? src[H-1:0]
                          : (neg ? {1'b1, {(H-1){1'b0}}} : {1'b0, {(H-1){1'b1}}});
            CLAMP_U:  sat = u_fit ? src[H-1:0] : {H{1'b1}};
            default:  sat = neg ? '0 : (u_fit ? src[H-1:0] : {H{1'b1}});
        endcase
    end

    // Place into the wide slot.
    always_comb begin
        slot = top ? {sat, dst_lo} : {{H{1'b0}}, sat};
    end
endmodule

// File: rtl/vnarrow_lane.sv
// One 64-bit lane: builds the result for every element width in
// parallel and picks the one named by the width code.
// Assumes LANE_W is divisible by 64, the widest element.
module vnarrow_lane
    import vnarrow_pkg::*;
(
    input  logic [LANE_W-1:0] src,
    input  logic [LANE_W-1:0] dst,
    input  nar_ctl_t          ctl,
    output logic [LANE_W-1:0] res
);
    localparam int unsigned N16 = LANE_W / 16;
    localparam int unsigned N32 = LANE_W / 32;
    localparam int unsigned N64 = LANE_W / 64;

    logic [LANE_W-1:0] r16, r32, r64;

    for (genvar k = 0; k < N16; k++) begin : g_e16
        vnarrow_elem #(.E(16)) u_elem (
            .src(src[k*16 +: 16]), .dst_lo(dst[k*16 +: 8]),
            .mode(ctl.mode), .top(ctl.top), .slot(r16[k*16 +: 16]));
    end
    for (genvar k = 0; k < N32; k++) begin : g_e32
        vnarrow_elem #(.E(32)) u_elem (
            .src(src[k*32 +: 32]), .dst_lo(dst[k*32 +: 16]),
            .mode(ctl.mode), .top(ctl.top), .slot(r32[k*32 +: 32]));
    end
    for (genvar k = 0; k < N64; k++) begin : g_e64
        vnarrow_elem #(.E(64)) u_elem (
            .src(src[k*64 +: 64]), .dst_lo(dst[k*64 +: 32]),
            .mode(ctl.mode), .top(ctl.top), .slot(r64[k*64 +: 64]));
    end

    // Width select.
    always_comb begin
        unique case (ctl.ew)
            EW16:    res = r16;
            EW32:    res = r32;
            default: res = r64;
        endcase
    end
endmodule

// File: rtl/vnarrow_sat.sv
// Saturating narrow-and-place unit, top level. It decodes the request,
// narrows all lanes in parallel and registers the result one cycle
// later. Illegal requests raise out_illegal and leave out_vec as it was.
// Assumes VEC_W is a multiple of 64; synchronous active-low reset.
module vnarrow_sat
    import vnarrow_pkg::*;
#(
    parameter int unsigned VEC_W   = 128,
    parameter int unsigned SHAMT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [2:0]         op_code,
    input  logic [1:0]         size_code,
    input  logic [SHAMT_W-1:0] shift_imm,
    input  logic [VEC_W-1:0]   src_vec,
    input  logic [VEC_W-1:0]   dst_vec,
    output logic [VEC_W-1:0]   out_vec,
    output logic               out_valid,
    output logic               out_illegal
);
    localparam int unsigned NLANE = VEC_W / LANE_W;

    nar_ctl_t         ctl;
    logic [VEC_W-1:0] res;

    vnarrow_dec #(.SHAMT_W(SHAMT_W)) u_dec (
        .op_code(op_code), .size_code(size_code),
        .shift_imm(shift_imm), .ctl(ctl));

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        vnarrow_lane u_lane (
            .src(src_vec[l*LANE_W +: LANE_W]),
            .dst(dst_vec[l*LANE_W +: LANE_W]),
            .ctl(ctl),
            .res(res[l*LANE_W +: LANE_W]));
    end

    // Output register: strobe, flag and result update on legal requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vec     <= '0;
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
        end else begin
            out_valid   <= in_valid;
            out_illegal <= in_valid & ~ctl.ok;
            if (in_valid && ctl.ok) begin
                out_vec <= res;
            end
        end
    end
endmodule

// File: rtl/vnarrow_sat_chk.sv
// Checker for vnarrow_sat: timing of the strobe, rejection hold, and
// half-slot contents per placement form. Attached by bind below.
module vnarrow_sat_chk #(
    parameter int unsigned VEC_W   = 128,
    parameter int unsigned SHAMT_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [2:0]         op_code,
    input logic [1:0]         size_code,
    input logic [SHAMT_W-1:0] shift_imm,
    input logic [VEC_W-1:0]   dst_vec,
    input logic [VEC_W-1:0]   out_vec,
    input logic               out_valid,
    input logic               out_illegal
);
    // Mask of the upper half of every wide slot for a width code.
    function automatic logic [VEC_W-1:0] hi_mask(input logic [1:0] sz);
        logic [VEC_W-1:0] m;
        int unsigned e;
        e = 16 << sz;
        m = '0;
        for (int b = 0; b < VEC_W; b++) begin
            if ((b % e) >= (e / 2)) m[b] = 1'b1;
        end
        return m;
    endfunction

    logic req_ok;
    assign req_ok = (size_code != 2'd3) && (shift_imm == '0) && (op_code[2:1] != 2'b11);

    p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_illegal && $stable(out_vec)));
    p_reject_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !req_ok) |=> (out_illegal && $stable(out_vec)));
    p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && req_ok) |=> !out_illegal);
    p_low_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && req_ok && !op_code[0]) |=>
        ((out_vec & hi_mask($past(size_code))) == '0));
    p_high_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && req_ok && op_code[0]) |=>
        (((out_vec ^ $past(dst_vec)) & ~hi_mask($past(size_code))) == '0));
endmodule

bind vnarrow_sat vnarrow_sat_chk #(.VEC_W(VEC_W), .SHAMT_W(SHAMT_W)) u_chk (.*);

// File: tb/vnarrow_sat_bench.sv
module vnarrow_sat_bench;
    localparam int unsigned VW = 128;
    localparam int unsigned SW = 3;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [2:0]    op_code;
    logic [1:0]    size_code;
    logic [SW-1:0] shift_imm;
    logic [VW-1:0] src_vec, dst_vec, out_vec;
    logic          out_valid, out_illegal;

    int n_chk = 0;
    int n_bad = 0;
    logic [VW-1:0] last_vec;

    always #(CLK_PERIOD/2) clk = ~clk;

    vnarrow_sat #(.VEC_W(VW), .SHAMT_W(SW)) u_vnarrow_sat (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .size_code(size_code), .shift_imm(shift_imm), .src_vec(src_vec),
        .dst_vec(dst_vec), .out_vec(out_vec), .out_valid(out_valid),
        .out_illegal(out_illegal));

    task automatic cmp(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Arithmetic reference from the requirements.
    function automatic logic [VW-1:0] model(input logic [2:0] op, input logic [1:0] sz,
                                            input logic [VW-1:0] s, input logic [VW-1:0] d);
        logic [VW-1:0] r;
        logic [63:0] w, dw, q, umax, emask, slot;
        longint sv, smax, smin;
        int e, h;
        e = 16 << sz;
        h = e / 2;
        r = '0;
        emask = (e == 64) ? '1 : ((64'd1 << e) - 1);
        umax = (64'd1 << h) - 1;
        smax = (64'sd1 <<< (h - 1)) - 1;
        smin = -smax - 1;
        for (int i = 0; i < VW / e; i++) begin
            w  = 64'(s >> (i * e)) & emask;
            dw = 64'(d >> (i * e)) & emask;
            sv = $signed(w << (64 - e)) >>> (64 - e);
            case (op[2:1])
                2'b00:   q = (sv > smax) ? 64'(smax) : (sv < smin) ? 64'(smin) : 64'(sv);
                2'b01:   q = (w > umax) ? umax : w;
                default: q = (sv < 0) ? 64'd0 : (sv > longint'(umax)) ? umax : 64'(sv);
            endcase
            q &= umax;
            slot = op[0] ? ((q << h) | (dw & umax)) : q;
            r |= VW'(slot) << (i * e);
        end
        return r;
    endfunction

    // Boundary candidates for wide width e, as e-bit patterns.
    function automatic logic [63:0] cand(input int e, input int k);
        longint v;
        int h;
        h = e / 2;
        case (k % 8)
            0: v = (64'sd1 <<< (h - 1)) - 1;
            1: v = (64'sd1 <<< (h - 1));
            2: v = -(64'sd1 <<< (h - 1));
            3: v = -(64'sd1 <<< (h - 1)) - 1;
            4: v = 0;
            5: v = -1;
            6: v = (64'sd1 <<< h) - 1;
            default: v = (64'sd1 <<< h);
        endcase
        return (e == 64) ? 64'(v) : (64'(v) & ((64'd1 << e) - 1));
    endfunction

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < VW / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    // Drive one request at a falling edge; returns at the next falling edge.
    task automatic issue(input logic [2:0] op, input logic [1:0] sz, input logic [SW-1:0] sh,
                         input logic [VW-1:0] s, input logic [VW-1:0] d);
        in_valid = 1'b1; op_code = op; size_code = sz; shift_imm = sh;
        src_vec = s; dst_vec = d;
        @(negedge clk);
    endtask

    task automatic idle();
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    function automatic string mtag(input logic [2:0] op);
        string m;
        m = (op[2:1] == 2'b00) ? "R2" : (op[2:1] == 2'b01) ? "R3" : "R4";
        return {m, op[0] ? " R6 R1" : " R5 R1"};
    endfunction

    bit done = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [VW-1:0] s, d, e;
        rst_n = 1'b0; in_valid = 1'b0; op_code = '0; size_code = '0;
        shift_imm = '0; src_vec = '0; dst_vec = '0;
        @(negedge clk);
        @(negedge clk);
        // R9: reset state
        cmp("R9 out_vec", out_vec, '0);
        cmp("R9 out_valid", VW'(out_valid), '0);
        cmp("R9 out_illegal", VW'(out_illegal), '0);
        rst_n = 1'b1;
        @(negedge clk);

        // Boundary and random sweep over sizes, modes and placements (R1-related tags per check).
        for (int sz = 0; sz < 3; sz++) begin
            for (int p = 0; p < 12; p++) begin
                int ew;
                ew = 16 << sz;
                s = '0;
                if (p < 8) begin
                    for (int i = 0; i < VW / ew; i++) s |= VW'(cand(ew, p + i)) << (i * ew);
                end else begin
                    s = rnd_vec();
                end
                d = rnd_vec();
                for (int op = 0; op < 6; op++) begin
                    issue(3'(op), 2'(sz), '0, s, d);
                    e = model(3'(op), 2'(sz), s, d);
                    cmp(mtag(3'(op)), out_vec, e);
                    cmp("R8 valid", VW'({out_valid, out_illegal}), VW'(2'b10));
                    last_vec = e;
                end
            end
        end

        // R8: idle holds
        idle();
        cmp("R8 idle vec", out_vec, last_vec);
        cmp("R8 idle strobes", VW'({out_valid, out_illegal}), '0);

        // R7: rejection right after a legal result, for each illegal cause
        for (int c = 0; c < 4; c++) begin
            s = rnd_vec(); d = rnd_vec();
            issue(3'b001, 2'd1, '0, s, d);
            last_vec = model(3'b001, 2'd1, s, d);
            cmp("R6 R1 pre-reject", out_vec, last_vec);
            case (c)
                0: issue(3'b000, 2'd3, '0, rnd_vec(), rnd_vec());
                1: issue(3'b010, 2'd0, 3'd4, rnd_vec(), rnd_vec());
                2: issue(3'b110, 2'd0, '0, rnd_vec(), rnd_vec());
                default: issue(3'b111, 2'd2, '0, rnd_vec(), rnd_vec());
            endcase
            cmp("R7 hold", out_vec, last_vec);
            cmp("R7 flag", VW'({out_valid, out_illegal}), VW'(2'b11));
            idle();
            cmp("R8 after reject", VW'({out_valid, out_illegal}), '0);
        end

        // R9: reset clears a nonzero result
        rst_n = 1'b0;
        @(negedge clk);
        cmp("R9 reset again", out_vec, '0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule